// File: doc/BRIEF.md
# Banked Lane FIFO Serializer

This block takes the output of a channelizer that presents four complex frequency bins on every clock and turns it into a stream of one bin per clock. Each of the four input lanes is written into its own FIFO. No FIFO ever needs more than one write per clock, so each one maps onto an ordinary two-port memory. A read sequencer then visits the FIFOs in a fixed rotation and rebuilds the natural bin order on an AXI4-Stream master port.

A frame is 512 bins, which is 128 input beats. The block counts the beats it accepts. On the final lane of the final beat it stores a frame-end flag next to the sample, in the least significant bit of the FIFO word. At the output that bit is split off and driven onto TLAST. The 50-bit sample is zero-extended into a 64-bit TDATA.

Backpressure from TREADY stalls the reads and the samples stay buffered. If a FIFO fills, the input side refuses further beats. A beat offered while the block is refusing is dropped and sets a sticky overflow flag.

Top module: `lane_fifo_serializer`

## Requirements
- R1: While reset is asserted and right after it, `m_tvalid` is 0, `overflow` is 0 and `s_ready` is 1.
- R2: Lane k of `s_data` occupies bits `[k*50 +: 50]`. Output samples appear in the order lane 0, 1, 2, 3 of the oldest stored beat, then the same for the next beat, with no sample lost or repeated.
- R3: `m_tdata[49:0]` carries the sample unchanged and `m_tdata[63:50]` is always 0.
- R4: `m_tlast` is 1 only on the lane-3 sample of every 128th accepted beat, counting from reset. That sample is bin 511 of its frame.
- R5: At the start of a round (pointer at lane 0), `m_tvalid` is 1 only when all four FIFOs hold data. Within a round it stays 1 until lane 3 has been sent.
- R6: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R7: The lane pointer moves only on an accepted transfer, so no stall pattern skips or repeats a lane.
- R8: Each FIFO holds 128 entries. `s_ready` is 0 exactly when some FIFO is full.
- R9: A beat offered with `s_valid` 1 while `s_ready` is 0 is not stored and does not appear on the output. It sets `overflow`, which then stays 1 until reset.
- R10: Dropped beats do not advance the frame count, so the frame-end position follows accepted beats only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input beat present |
| s_data | input | 200 | Four 50-bit samples, lane k at bits k*50 |
| s_ready | output | 1 | Beat will be stored (no FIFO full) |
| m_tvalid | output | 1 | Stream sample valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 64 | Zero-extended sample |
| m_tlast | output | 1 | Last bin of a frame |
| overflow | output | 1 | Sticky: a beat was dropped |

## Verification
The assertions assume that the input side writes all four lanes together. Under that condition a FIFO visited later in a round never runs empty before the FIFOs ahead of it, so the hold and lane-pointer properties depend on it. The bench drives only whole four-lane beats, which keeps it inside that assumption. The stimulus covers continuous flow, sparse input under an irregular TREADY pattern, a full stop that fills every FIFO, and further offered beats that must be dropped. A behavioural model built from per-lane counts and a sample queue predicts `s_ready`, `m_tvalid`, `overflow` and each accepted sample on every clock.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    localparam int unsigned LFS_LANES      = 4;
    localparam int unsigned LFS_SAMPLE_W   = 50;
    localparam int unsigned LFS_DEPTH      = 128;
    localparam int unsigned LFS_FRAME_BINS = 512;
    localparam int unsigned LFS_AXI_W      = 64;

    // index width that never collapses to zero bits
    function automatic int unsigned idx_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lfs_lane_fifo.sv
module lfs_lane_fifo import lfs_pkg::*; #(
    parameter int unsigned WORD_W = 51,
    parameter int unsigned DEPTH  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic              empty,
    output logic              full
);
    localparam int unsigned AW = idx_w(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        empty = (st_q.cnt == '0);
        full  = (st_q.cnt == CW'(DEPTH));
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
        st_d  = st_q;
        if (do_wr) st_d.wp = bump(st_q.wp);
        if (do_rd) st_d.rp = bump(st_q.rp);
        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wp] <= wr_word;
    end

    assign rd_word = mem[st_q.rp];
endmodule

// File: rtl/lfs_write_ctrl.sv
module lfs_write_ctrl import lfs_pkg::*; #(
    parameter int unsigned LANES    = 4,
    parameter int unsigned SAMPLE_W = 50,
    parameter int unsigned BEATS    = 128
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [LANES*SAMPLE_W-1:0]       in_data,
    input  logic                            any_full,
    output logic                            in_ready,
    output logic                            wr_en,
    output logic [LANES*(SAMPLE_W+1)-1:0]   wr_words,
    output logic                            overflow
);
    localparam int unsigned BW     = idx_w(BEATS);
    localparam int unsigned WORD_W = SAMPLE_W + 1;

    typedef struct packed {
        logic [BW-1:0] beat;
        logic          ovf;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   last_beat;

    always_comb begin
        in_ready  = !any_full;
        wr_en     = in_valid && in_ready;
        last_beat = (st_q.beat == BW'(BEATS - 1));
        overflow  = st_q.ovf;
        st_d      = st_q;
        if (wr_en) st_d.beat = last_beat ? '0 : st_q.beat + BW'(1);
        if (in_valid && !in_ready) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // frame-end flag rides in bit 0; only the highest lane can carry it
    for (genvar k = 0; k < LANES; k++) begin : g_word
        localparam bit IS_END = (k == LANES - 1);
        assign wr_words[k*WORD_W +: WORD_W] =
            {in_data[k*SAMPLE_W +: SAMPLE_W], IS_END && last_beat};
    end
endmodule

// File: rtl/lfs_read_seq.sv
module lfs_read_seq import lfs_pkg::*; #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned WORD_W = 51,
    parameter int unsigned AXI_W  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           not_empty,
    input  logic [LANES*WORD_W-1:0]    words,
    input  logic                       m_tready,
    output logic [LANES-1:0]           pop,
    output logic                       m_tvalid,
    output logic [AXI_W-1:0]           m_tdata,
    output logic                       m_tlast,
    output logic [idx_w(LANES)-1:0]    cur_lane
);
    localparam int unsigned LW = idx_w(LANES);

    typedef struct packed {
        logic [LW-1:0] lane;
    } rd_st_t;

    rd_st_t            st_d, st_q;
    logic [WORD_W-1:0] sel;
    logic              fire;

    always_comb begin
        sel      = words[st_q.lane*WORD_W +: WORD_W];
        // a round opens only when every bank can supply its sample
        m_tvalid = (st_q.lane == '0) ? &not_empty : not_empty[st_q.lane];
        fire     = m_tvalid && m_tready;
        m_tdata  = '0;
        m_tdata[WORD_W-2:0] = sel[WORD_W-1:1];
        m_tlast  = sel[0];
        pop      = '0;
        st_d     = st_q;
        if (fire) begin
            pop[st_q.lane] = 1'b1;
            st_d.lane = (st_q.lane == LW'(LANES - 1)) ? '0 : st_q.lane + LW'(1);
        end
        cur_lane = st_q.lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lane_fifo_serializer.sv
module lane_fifo_serializer import lfs_pkg::*; #(
    parameter int unsigned LANES      = LFS_LANES,
    parameter int unsigned SAMPLE_W   = LFS_SAMPLE_W,
    parameter int unsigned DEPTH      = LFS_DEPTH,
    parameter int unsigned FRAME_BINS = LFS_FRAME_BINS,
    parameter int unsigned AXI_W      = LFS_AXI_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s_valid,
    input  logic [LANES*SAMPLE_W-1:0] s_data,
    output logic                      s_ready,
    output logic                      m_tvalid,
    input  logic                      m_tready,
    output logic [AXI_W-1:0]          m_tdata,
    output logic                      m_tlast,
    output logic                      overflow
);
    localparam int unsigned BEATS  = FRAME_BINS / LANES;
    localparam int unsigned WORD_W = SAMPLE_W + 1;
    localparam int unsigned LW     = idx_w(LANES);

    logic                      wr_en;
    logic [LANES*WORD_W-1:0]   wr_words;
    logic [LANES*WORD_W-1:0]   rd_words;
    logic [LANES-1:0]          full_v;
    logic [LANES-1:0]          empty_v;
    logic [LANES-1:0]          pop;
    logic                      any_full;
    logic [LW-1:0]             rd_lane;

    assign any_full = |full_v;

    lfs_write_ctrl #(
        .LANES(LANES), .SAMPLE_W(SAMPLE_W), .BEATS(BEATS)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s_valid), .in_data(s_data), .any_full(any_full),
        .in_ready(s_ready), .wr_en(wr_en), .wr_words(wr_words),
        .overflow(overflow)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        lfs_lane_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en), .wr_word(wr_words[k*WORD_W +: WORD_W]),
            .rd_en(pop[k]), .rd_word(rd_words[k*WORD_W +: WORD_W]),
            .empty(empty_v[k]), .full(full_v[k])
        );
    end

    lfs_read_seq #(
        .LANES(LANES), .WORD_W(WORD_W), .AXI_W(AXI_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .not_empty(~empty_v), .words(rd_words), .m_tready(m_tready),
        .pop(pop), .m_tvalid(m_tvalid), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .cur_lane(rd_lane)
    );
endmodule

// File: rtl/lane_fifo_serializer_chk.sv
module lane_fifo_serializer_chk #(
    parameter int unsigned AXI_W    = 64,
    parameter int unsigned SAMPLE_W = 50,
    parameter int unsigned LANES    = 4,
    parameter int unsigned LW       = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_valid,
    input logic             s_ready,
    input logic             m_tvalid,
    input logic             m_tready,
    input logic [AXI_W-1:0] m_tdata,
    input logic             m_tlast,
    input logic             overflow,
    input logic [LW-1:0]    rd_lane
);
    a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ((m_tdata >> SAMPLE_W) == '0));

    a_r4_last_on_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tlast) |-> (rd_lane == LW'(LANES - 1)));

    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    a_r7_lane_waits: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_tvalid && m_tready) |=> $stable(rd_lane));

    a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_ready) |=> overflow);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind lane_fifo_serializer lane_fifo_serializer_chk #(
    .AXI_W(AXI_W), .SAMPLE_W(SAMPLE_W), .LANES(LANES), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tlast(m_tlast), .overflow(overflow), .rd_lane(rd_lane)
);

// File: tb/lane_fifo_serializer_tb.sv
module lane_fifo_serializer_tb;
    localparam int LANES = 4;
    localparam int SW    = 50;
    localparam int DEPTH = 128;
    localparam int BEATS = 128;
    localparam int AXW   = 64;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  s_valid = 1'b0;
    logic [LANES*SW-1:0]   s_data = '0;
    logic                  s_ready;
    logic                  m_tvalid;
    logic                  m_tready = 1'b0;
    logic [AXW-1:0]        m_tdata;
    logic                  m_tlast;
    logic                  overflow;

    lane_fifo_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tlast(m_tlast), .overflow(overflow)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural model state
    logic [SW:0] exp_q[$];
    int  lane_cnt[LANES];
    int  rr = 0;
    int  beat = 0;
    int  next_id = 0;
    bit  exp_ovf = 1'b0;
    bit  prev_stall = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [SW-1:0] lane_val(input int id, input int k);
        logic [63:0] x;
        x = 64'(id * LANES + k + 1) * 64'h9E37_79B9_7F4A_7C15;
        return x[63 -: SW];
    endfunction

    function automatic logic [LANES*SW-1:0] beat_data(input int id);
        logic [LANES*SW-1:0] d;
        for (int k = 0; k < LANES; k++) d[k*SW +: SW] = lane_val(id, k);
        return d;
    endfunction

    task automatic cycle(input bit v, input bit rdy);
        bit exp_ready, exp_valid;
        logic [SW:0] front;
        @(negedge clk);
        exp_ready = 1'b1;
        for (int k = 0; k < LANES; k++) if (lane_cnt[k] >= DEPTH) exp_ready = 1'b0;
        if (rr == 0) begin
            exp_valid = 1'b1;
            for (int k = 0; k < LANES; k++) if (lane_cnt[k] == 0) exp_valid = 1'b0;
        end else begin
            exp_valid = (lane_cnt[rr] > 0);
        end
        chk(s_ready == exp_ready, "R8", "s_ready", 64'(s_ready), 64'(exp_ready));
        chk(m_tvalid == exp_valid, "R5", "m_tvalid", 64'(m_tvalid), 64'(exp_valid));
        chk(overflow == exp_ovf, "R9", "overflow", 64'(overflow), 64'(exp_ovf));
        if (exp_valid && m_tvalid) begin
            front = exp_q[0];
            chk(m_tdata[SW-1:0] == front[SW:1], prev_stall ? "R6" : "R2",
                "sample", 64'(m_tdata[SW-1:0]), 64'(front[SW:1]));
            chk(m_tdata[AXW-1:SW] == '0, "R3", "pad bits",
                64'(m_tdata[AXW-1:SW]), 64'd0);
            chk(m_tlast == front[0], "R4/R10", "tlast", 64'(m_tlast), 64'(front[0]));
        end
        // drive the next cycle's inputs
        s_valid  = v;
        s_data   = beat_data(next_id);
        m_tready = rdy;
        // model the coming edge: pop from pre-edge state, then store
        if (exp_valid && rdy) begin
            void'(exp_q.pop_front());
            lane_cnt[rr]--;
            rr = (rr + 1) % LANES;
        end
        prev_stall = exp_valid && !rdy;
        if (v) begin
            if (exp_ready) begin
                for (int k = 0; k < LANES; k++) begin
                    exp_q.push_back({lane_val(next_id, k),
                                     (k == LANES - 1) && (beat == BEATS - 1)});
                    lane_cnt[k]++;
                end
                beat = (beat + 1) % BEATS;
            end else begin
                exp_ovf = 1'b1;   // R9 dropped beat, R10 no count
            end
        end
        next_id++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < LANES; k++) lane_cnt[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R1", "tvalid in reset", 64'(m_tvalid), 64'd0);
        chk(overflow == 1'b0, "R1", "overflow in reset", 64'(overflow), 64'd0);
        chk(s_ready == 1'b1, "R1", "s_ready in reset", 64'(s_ready), 64'd1);
        rst_n = 1'b1;
        // continuous frame, sink always ready
        for (int i = 0; i < BEATS; i++) cycle(1'b1, 1'b1);
        // sparse input, irregular stalls (R7)
        for (int i = 0; i < 600; i++) cycle((i % 4) == 0, ((i * 7) % 5) < 3);
        for (int i = 0; i < 300; i++) cycle(1'b0, 1'b1);
        // fill every bank, then offer beats that must be dropped (R8, R9)
        for (int i = 0; i < DEPTH + 3; i++) cycle(1'b1, 1'b0);
        for (int i = 0; i < 200; i++) cycle(1'b0, (i % 3) == 1);
        for (int i = 0; i < 600; i++) cycle(1'b0, 1'b1);
        // frame boundary after the drops (R10)
        for (int i = 0; i < 120; i++) cycle(1'b1, (i % 2) == 0);
        for (int i = 0; i < 700; i++) cycle(1'b0, 1'b1);
        chk(exp_q.size() == 0, "R2", "queue drained", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule